// File: doc/BRIEF.md
# Byte-Serial Little-Endian Load/Store Port

This block sits between a processor core and a data memory that has one 8-bit port. It carries out 8-, 16- and 32-bit loads and stores by breaking each access into a series of single-byte transfers. The transfers go to consecutive byte addresses, one per clock. The address of a multi-byte element is the lowest byte address it covers. The least significant byte sits at that address and each more significant byte sits one address higher.

The core starts an access with a one-cycle request while the port is idle. The request carries a base address, a size code and a direction, plus the write word for stores. The port then reports busy until the access finishes, and marks completion with a one-cycle done pulse. For a load, the assembled, zero-extended word appears on the result output together with done. All outputs toward memory and toward the core are registered. The memory is expected to return read data one cycle after it samples a read access, which is how a synchronous block RAM behaves.

Top module: `byte_lsu`

## Requirements
- R1: The size code sets the number of byte transfers: 2'b00 gives one, 2'b01 gives two, 2'b10 gives four, and the spare code 2'b11 is handled like 2'b10 (four).
- R2: The byte transfers start at the base address and go up by one address per clock, with no idle cycle between them. Address arithmetic wraps modulo 2^16, so 0xFFFF is followed by 0x0000.
- R3: A store writes data bits [8k+7:8k] to address base+k, for k from 0 up to the transfer count minus one, and writes no other address.
- R4: A load places the byte read from base+k in result bits [8k+7:8k] and returns zero in every bit above the transferred bytes.
- R5: For an access of n transfers, done is high for exactly one cycle, beginning n+1 rising edges after the edge that accepted the request. This holds for both loads and stores.
- R6: busy goes high on the accepting edge and stays high until the edge that raises done. A request presented while busy is ignored: it produces no memory transfer and does not change the access in flight.
- R7: After synchronous reset, busy, done and the memory enable are low and the result is zero.
- R8: The memory is sampled with read data valid one cycle after a read access. The port drives write enable only together with memory enable.
- R9: The result output changes only when a load completes. A store leaves it holding the value of the previous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code (see R1) |
| req_addr | input | 16 | Base byte address |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Zero-extended load result |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after a read |

## Verification
The bench stores a word and reads it back, and it stores and loads halfwords and single bytes. The addresses are chosen so that neighbouring bytes carry known values that must survive. A store ordered the wrong way would scramble the distinct byte values of 0x12345678, and a lane that is placed incorrectly would also show up in those values. A load over 0xFF-filled bytes tells zero-extension apart from stale or sign-filled upper bits. A word store at 0xFFFE shows whether the address wraps at 16 bits. A request held during an access shows whether it is ignored. The spare size code and latency counting show whether the transfer count follows the size code.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_SPARE = 2'b11
  } lsu_size_e;

  // highest lane index touched for a size code, clipped to the lane count
  function automatic int unsigned last_lane(input logic [1:0] sz, input int unsigned lanes);
    int unsigned n;
    n = 1 << sz;
    if (n > lanes) n = lanes;
    return n - 1;
  endfunction
endpackage

// File: rtl/lsu_beat_seq.sv
module lsu_beat_seq #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] base,
  output logic              busy,
  output logic              beat_en,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              at_last,
  output logic              tail,
  output logic              cap_valid,
  output logic [IDX_W-1:0]  cap_idx,
  input  logic              is_write
);
  logic [IDX_W-1:0] last_q;

  assign at_last = beat_en && (beat_idx == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      beat_en   <= 1'b0;
      beat_addr <= '0;
      beat_idx  <= '0;
      last_q    <= '0;
      tail      <= 1'b0;
      cap_valid <= 1'b0;
      cap_idx   <= '0;
    end else begin
      cap_valid <= beat_en && !is_write;
      cap_idx   <= beat_idx;
      if (start) begin
        busy      <= 1'b1;
        beat_en   <= 1'b1;
        beat_addr <= base;
        beat_idx  <= '0;
        last_q    <= IDX_W'(lsu_pkg::last_lane(size, LANES));
        tail      <= 1'b0;
      end else if (beat_en) begin
        if (beat_idx == last_q) begin
          beat_en <= 1'b0;
          tail    <= 1'b1;
        end else begin
          beat_idx  <= beat_idx + 1'b1;
          beat_addr <= beat_addr + 1'b1;
        end
      end else if (tail) begin
        tail <= 1'b0;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsu_scatter.sv
module lsu_scatter #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*BYTE_W-1:0] word,
  input  logic [IDX_W-1:0]        lane,
  output logic [BYTE_W-1:0]       lane_byte
);
  logic [BYTE_W-1:0] lanes_a [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_a[g] = word[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    lane_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (IDX_W'(i) == lane) lane_byte = lanes_a[i];
    end
  end
endmodule

// File: rtl/lsu_gather.sv
module lsu_gather #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    cap_valid,
  input  logic [IDX_W-1:0]        cap_idx,
  input  logic [BYTE_W-1:0]       cap_byte,
  output logic [LANES*BYTE_W-1:0] merged
);
  logic [LANES*BYTE_W-1:0] acc_q;

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    always_comb begin
      if (cap_valid && cap_idx == IDX_W'(g)) merged[g*BYTE_W +: BYTE_W] = cap_byte;
      else                                   merged[g*BYTE_W +: BYTE_W] = acc_q[g*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (cap_valid) acc_q <= merged;
  end
endmodule

// File: rtl/byte_lsu.sv
module byte_lsu #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic              start;
  logic              at_last;
  logic              tail;
  logic              cap_valid;
  logic [IDX_W-1:0]  cap_idx;
  logic [IDX_W-1:0]  beat_idx;
  logic [IDX_W-1:0]  next_lane;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] scatter_src;
  logic [BYTE_W-1:0] next_byte;
  logic [DATA_W-1:0] merged;
  logic              write_q;

  assign start       = req_valid && !busy;
  assign next_lane   = start ? '0 : beat_idx + 1'b1;
  assign scatter_src = start ? req_wdata : wdata_q;

  lsu_beat_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .size      (req_size),
    .base      (req_addr),
    .busy      (busy),
    .beat_en   (mem_en),
    .beat_addr (mem_addr),
    .beat_idx  (beat_idx),
    .at_last   (at_last),
    .tail      (tail),
    .cap_valid (cap_valid),
    .cap_idx   (cap_idx),
    .is_write  (write_q)
  );

  lsu_scatter #(.BYTE_W(BYTE_W), .LANES(LANES)) scatter_i (
    .word      (scatter_src),
    .lane      (next_lane),
    .lane_byte (next_byte)
  );

  lsu_gather #(.BYTE_W(BYTE_W), .LANES(LANES)) gather_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start),
    .cap_valid (cap_valid),
    .cap_idx   (cap_idx),
    .cap_byte  (mem_rdata),
    .merged    (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      write_q   <= 1'b0;
      wdata_q   <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= tail;
      if (tail && !write_q) rdata <= merged;
      if (start) begin
        write_q   <= req_write;
        wdata_q   <= req_wdata;
        mem_we    <= req_write;
        mem_wdata <= next_byte;
      end else if (at_last) begin
        mem_we <= 1'b0;
      end else if (mem_en) begin
        mem_wdata <= next_byte;
      end
    end
  end
endmodule

// File: rtl/byte_lsu_chk.sv
module byte_lsu_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R6
  mem_in_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_en |-> busy);
  // R8
  we_with_en_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_en);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en) && !$rose(busy) && $stable(busy)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(rdata));
endmodule

bind byte_lsu byte_lsu_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .rdata    (rdata),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/byte_lsu_tb_top.sv
module byte_lsu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, mem_en, mem_we;
  logic [31:0] rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem [256];
  logic [15:0] wlog [16];
  int          wcnt = 0;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  byte_lsu dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        if (wcnt < 16) wlog[wcnt] <= mem_addr;
        wcnt <= wcnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one access; returns rising edges from acceptance to done
  task automatic run(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                     input logic [31:0] d, input bit hold_other, output int lat);
    @(negedge clk);
    wcnt = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (hold_other) begin
      req_write = 1'b1; req_size = 2'b00; req_addr = 16'h0080; req_wdata = 32'h55;
    end else begin
      req_valid = 1'b0;
    end
    chk("R6 busy after accept", {31'd0, busy}, 32'd1);
    lat = 0;
    while (!done && lat < 50) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R5 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R7 busy", {31'd0, busy}, 32'd0);
    chk("R7 done", {31'd0, done}, 32'd0);
    chk("R7 mem_en", {31'd0, mem_en}, 32'd0);
    chk("R7 rdata", rdata, 32'd0);
  endtask

  task automatic t_store_word();
    int lat;
    for (int i = 0; i < 6; i++) mem[i] = 8'hEE;
    run(1'b1, 2'b10, 16'h5000, 32'h12345678, 1'b0, lat);
    chk("R3 byte0", {24'd0, mem[0]}, 32'h78);
    chk("R3 byte1", {24'd0, mem[1]}, 32'h56);
    chk("R3 byte2", {24'd0, mem[2]}, 32'h34);
    chk("R3 byte3", {24'd0, mem[3]}, 32'h12);
    chk("R3 beyond untouched", {24'd0, mem[4]}, 32'hEE);
    chk("R2 first addr", {16'd0, wlog[0]}, 32'h5000);
    chk("R2 last addr", {16'd0, wlog[3]}, 32'h5003);
    chk("R1 word count", wcnt, 32'd4);
    chk("R5 store latency", lat, 32'd5);
  endtask

  task automatic t_load_word();
    int lat;
    run(1'b0, 2'b10, 16'h5000, 32'h0, 1'b0, lat);
    chk("R4 word load", rdata, 32'h12345678);
    chk("R5 load latency", lat, 32'd5);
  endtask

  task automatic t_half();
    int lat;
    mem[2] = 8'hC3;
    run(1'b1, 2'b01, 16'h0500, 32'hAAAABEEF, 1'b0, lat);
    chk("R3 half lo", {24'd0, mem[0]}, 32'hEF);
    chk("R3 half hi", {24'd0, mem[1]}, 32'hBE);
    chk("R3 half neighbour", {24'd0, mem[2]}, 32'hC3);
    chk("R5 half latency", lat, 32'd3);
    chk("R9 store keeps rdata", rdata, 32'h12345678);
    for (int i = 16; i < 20; i++) mem[i] = 8'hFF;
    run(1'b0, 2'b01, 16'h0010, 32'h0, 1'b0, lat);
    chk("R4 half zero-extend", rdata, 32'h0000FFFF);
  endtask

  task automatic t_byte();
    int lat;
    mem[8'h31] = 8'h11; mem[8'h32] = 8'h22; mem[8'h33] = 8'h80;
    run(1'b1, 2'b00, 16'h0032, 32'hFFFFFF5A, 1'b0, lat);
    chk("R3 byte stored", {24'd0, mem[8'h32]}, 32'h5A);
    chk("R3 below untouched", {24'd0, mem[8'h31]}, 32'h11);
    chk("R3 above untouched", {24'd0, mem[8'h33]}, 32'h80);
    chk("R1 byte count", wcnt, 32'd1);
    run(1'b0, 2'b00, 16'h0033, 32'h0, 1'b0, lat);
    chk("R4 byte zero-extend", rdata, 32'h00000080);
    chk("R5 byte latency", lat, 32'd2);
  endtask

  task automatic t_wrap();
    int lat;
    run(1'b1, 2'b10, 16'hFFFE, 32'hA1B2C3D4, 1'b0, lat);
    chk("R2 wrap a0", {16'd0, wlog[0]}, 32'hFFFE);
    chk("R2 wrap a1", {16'd0, wlog[1]}, 32'hFFFF);
    chk("R2 wrap a2", {16'd0, wlog[2]}, 32'h0000);
    chk("R2 wrap a3", {16'd0, wlog[3]}, 32'h0001);
    chk("R3 wrap data", {mem[1], mem[0], mem[8'hFF], mem[8'hFE]}, 32'hA1B2C3D4);
  endtask

  task automatic t_busy_ignore();
    int lat;
    mem[8'h80] = 8'hAA;
    run(1'b1, 2'b10, 16'h0040, 32'h0BADF00D, 1'b1, lat);
    chk("R6 held request no write", {24'd0, mem[8'h80]}, 32'hAA);
    chk("R6 only own beats", wcnt, 32'd4);
    chk("R6 access intact", {mem[8'h43], mem[8'h42], mem[8'h41], mem[8'h40]}, 32'h0BADF00D);
  endtask

  task automatic t_spare_size();
    int lat;
    mem[8'h20] = 8'h01; mem[8'h21] = 8'h02; mem[8'h22] = 8'h03; mem[8'h23] = 8'h04;
    run(1'b0, 2'b11, 16'h0020, 32'h0, 1'b0, lat);
    chk("R1 spare code as word", rdata, 32'h04030201);
    chk("R1 spare code latency", lat, 32'd5);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store_word();
    t_load_word();
    t_half();
    t_byte();
    t_wrap();
    t_busy_ignore();
    t_spare_size();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule